// File: doc/BRIEF.md
# Virtual-Channel Credit Tracker

This block sits on the sending side of a link between two routers. It keeps a separate count of free buffer slots for every virtual channel at the receiving end. Each time the local switch allocator sends a flit on a virtual channel, that channel's count goes down by one. Each time the receiver frees a slot and returns a credit over the separate return path, the matching count goes up by one. A per-channel permission bit tells the allocator which channels may send in the current cycle.

Credits come back after a round-trip delay. Sustained throughput on one channel therefore depends on how the per-channel buffer depth compares with that delay. The block does not carry flit data and does not make routing or allocation decisions. It enforces the counting rules, starts every counter at full buffer depth, and flags protocol errors in both directions.

Top module: `vc_credit_tracker`

## Requirements
- R1: After a synchronous active-low reset, every channel's count equals the buffer depth (default 3). Every may-send bit is 1, and both error vectors are 0.
- R2: A send on channel v whose count is nonzero lowers that count by exactly one, visible after the next rising clock edge.
- R3: A send on a channel whose count is 0 is ignored, so the count stays 0. Bit v of the underflow vector is 1 for exactly the one cycle after that edge.
- R4: A credit return (valid bit high, channel id v) on a channel below full depth raises that count by one after the next edge.
- R5: A send and a credit return on the same channel in the same cycle leave the count unchanged, including at full depth, and set no error bit.
- R6: A credit return on a channel already at full depth with no send on it does not increment the count. Bit v of the overflow vector is 1 for exactly the one cycle after that edge.
- R7: Channels are independent. A send on one channel and a credit return on another in the same cycle each update only their own count.
- R8: may-send bit v is 1 exactly when channel v's count is nonzero.
- R9: Under a receiver that returns every credit a fixed number of cycles after the send, and a sender that sends whenever allowed, no error bit is ever raised. After the traffic drains, each count is back at full depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| send_valid | input | 1 | A flit is sent this cycle |
| send_vc | input | VCW | Channel id of the sent flit |
| ret_valid | input | 1 | A credit returns this cycle |
| ret_vc | input | VCW | Channel id of the returned credit |
| may_send | output | NUM_VC | Bit v: channel v has a free downstream slot |
| credit_cnt | output | NUM_VC*CW | Packed counts, channel v at bits [v*CW +: CW] |
| ovf_err | output | NUM_VC | One-cycle pulse: credit returned to a full counter |
| udf_err | output | NUM_VC | One-cycle pulse: send attempted at zero credit |

## Verification
A counter that loses or gains a credit shows up on the ports at once, through the count bus and the may-send bit of that channel. It keeps showing up: a drifted count never corrects itself, so a stuck-high count eventually produces an overflow pulse when the real credits return, and a low count makes may-send drop early. The directed scenarios walk one channel down to zero and back up to full, and read the count one edge after each event. In the streaming run with a credit delay, a single mis-handled event becomes a permanent offset that the final full-depth check exposes.

// File: rtl/credit_pkg.sv
// Shared types for the credit tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package credit_pkg;

    // Net action applied to one counter in a cycle.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DEC  = 2'd1,
        ACT_INC  = 2'd2
    } cnt_act_e;

    // Width needed to hold values 0..depth inclusive.
    function automatic int cnt_width(input int depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/credit_vc_decode.sv
// Turns a (valid, channel id) pair into a one-hot per-channel strobe.
// Assumes: ids at or above NUM_VC select no channel.
module credit_vc_decode #(
    parameter int NUM_VC = 2,
    parameter int VCW    = 1
) (
    input  logic              valid,
    input  logic [VCW-1:0]    vc,
    output logic [NUM_VC-1:0] sel
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_VC; gi++) begin : g_sel
            // One comparator per channel.
            assign sel[gi] = valid && (vc == VCW'(gi));
        end
    endgenerate

endmodule

// File: rtl/credit_counter.sv
// Credit counter for one downstream virtual channel.
// Sends are accepted only at nonzero count. Returns are accepted below full
// depth, or when paired with an accepted send. Rejected events pulse an
// error flag one cycle later.
// Assumes: at most one send and one return per cycle for this channel.
module credit_counter
    import credit_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CW    = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send,
    input  logic          ret,
    output logic [CW-1:0] cnt,
    output logic          may_send,
    output logic          ovf,
    output logic          udf
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic     send_ok;
    logic     ret_ok;
    cnt_act_e act;

    // Decide which events are legal this cycle.
    always_comb begin
        send_ok = send && (cnt != '0);
        ret_ok  = ret && ((cnt != FULL) || send_ok);
    end

    // Reduce the accepted events to a single net action.
    always_comb begin
        if (send_ok && !ret_ok)      act = ACT_DEC;
        else if (ret_ok && !send_ok) act = ACT_INC;
        else                         act = ACT_HOLD;
    end

    // Counter register, loaded with full depth at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else begin
            unique case (act)
                ACT_DEC:  cnt <= cnt - 1'b1;
                ACT_INC:  cnt <= cnt + 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    // Error pulses for rejected events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            ovf <= ret && !ret_ok;
            udf <= send && !send_ok;
        end
    end

    // Permission to send.
    assign may_send = (cnt != '0);

    assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !ret && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    assert_hold_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !ret && cnt == '0) |=> (cnt == '0 && udf));
    assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !send && cnt != FULL) |=> (cnt == $past(cnt) + 1'b1));
    assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ret && cnt != '0) |=> ($stable(cnt) && !ovf && !udf));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !send && cnt == FULL) |=> (ovf && cnt == FULL));

endmodule

// File: rtl/vc_credit_tracker.sv
// Upstream credit tracker for NUM_VC downstream virtual channels.
// Decodes the send and return strobes per channel and keeps one counter per
// channel. Exposes counts, permissions and error pulses.
// Assumes: at most one send and one credit return per cycle on the link.
module vc_credit_tracker
    import credit_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 3,
    parameter int VCW    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    parameter int CW     = cnt_width(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_valid,
    input  logic [VCW-1:0]       send_vc,
    input  logic                 ret_valid,
    input  logic [VCW-1:0]       ret_vc,
    output logic [NUM_VC-1:0]    may_send,
    output logic [NUM_VC*CW-1:0] credit_cnt,
    output logic [NUM_VC-1:0]    ovf_err,
    output logic [NUM_VC-1:0]    udf_err
);

    logic [NUM_VC-1:0] send_sel;
    logic [NUM_VC-1:0] ret_sel;

    // Per-channel send strobes.
    credit_vc_decode #(.NUM_VC(NUM_VC), .VCW(VCW)) u_send_dec (
        .valid (send_valid),
        .vc    (send_vc),
        .sel   (send_sel)
    );

    // Per-channel credit-return strobes.
    credit_vc_decode #(.NUM_VC(NUM_VC), .VCW(VCW)) u_ret_dec (
        .valid (ret_valid),
        .vc    (ret_vc),
        .sel   (ret_sel)
    );

    genvar gv;
    generate
        for (gv = 0; gv < NUM_VC; gv++) begin : g_vc
            // One independent counter per channel.
            credit_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .send     (send_sel[gv]),
                .ret      (ret_sel[gv]),
                .cnt      (credit_cnt[gv*CW +: CW]),
                .may_send (may_send[gv]),
                .ovf      (ovf_err[gv]),
                .udf      (udf_err[gv])
            );
        end
    endgenerate

    assert_blocked_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid && (int'(send_vc) < NUM_VC) && !may_send[send_vc])
        |=> udf_err[$past(send_vc)]);
    assert_err_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovf_err) && $onehot0(udf_err));

endmodule

// File: tb/vc_credit_tracker_tb.sv
// Directed bench for vc_credit_tracker: one task per scenario.
module vc_credit_tracker_tb;

    localparam int NUM_VC = 2;
    localparam int DEPTH  = 3;
    localparam int VCW    = 1;
    localparam int CW     = 2;
    localparam int LAT    = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 send_valid = 1'b0;
    logic [VCW-1:0]       send_vc = '0;
    logic                 ret_valid = 1'b0;
    logic [VCW-1:0]       ret_vc = '0;
    logic [NUM_VC-1:0]    may_send;
    logic [NUM_VC*CW-1:0] credit_cnt;
    logic [NUM_VC-1:0]    ovf_err;
    logic [NUM_VC-1:0]    udf_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    vc_credit_tracker #(.NUM_VC(NUM_VC), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .send_valid (send_valid),
        .send_vc    (send_vc),
        .ret_valid  (ret_valid),
        .ret_vc     (ret_vc),
        .may_send   (may_send),
        .credit_cnt (credit_cnt),
        .ovf_err    (ovf_err),
        .udf_err    (udf_err)
    );

    always #5 clk = ~clk;

    function automatic int cnt_of(input int v);
        return int'(credit_cnt[v*CW +: CW]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then sample after the edge.
    task automatic cycle(input bit sv, input int svc, input bit rv, input int rvc);
        send_valid = sv;
        send_vc    = VCW'(svc);
        ret_valid  = rv;
        ret_vc     = VCW'(rvc);
        @(posedge clk);
        @(negedge clk);
        send_valid = 1'b0;
        ret_valid  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cnt vc0", cnt_of(0), DEPTH);
        check("R1 cnt vc1", cnt_of(1), DEPTH);
        check("R1 may_send", int'(may_send), 3);
        check("R1 ovf", int'(ovf_err), 0);
        check("R1 udf", int'(udf_err), 0);
    endtask

    task automatic t_drain();
        for (int i = 1; i <= DEPTH; i++) begin
            cycle(1'b1, 0, 1'b0, 0);
            check("R2 drain vc0", cnt_of(0), DEPTH - i);
            check("R7 vc1 untouched", cnt_of(1), DEPTH);
        end
        check("R8 may_send at zero", int'(may_send), 2);
    endtask

    task automatic t_underflow();
        cycle(1'b1, 0, 1'b0, 0);
        check("R3 count held", cnt_of(0), 0);
        check("R3 udf pulse", int'(udf_err), 1);
        cycle(1'b0, 0, 1'b0, 0);
        check("R3 udf cleared", int'(udf_err), 0);
    endtask

    task automatic t_paired();
        cycle(1'b0, 0, 1'b1, 0);
        check("R4 credit inc", cnt_of(0), 1);
        check("R8 may_send back", int'(may_send), 3);
        cycle(1'b1, 0, 1'b1, 0);
        check("R5 paired hold", cnt_of(0), 1);
        check("R5 no err", int'(ovf_err | udf_err), 0);
    endtask

    task automatic t_independent();
        cycle(1'b1, 1, 1'b1, 0);
        check("R7 vc0 inc", cnt_of(0), 2);
        check("R7 vc1 dec", cnt_of(1), DEPTH - 1);
    endtask

    task automatic t_overflow();
        cycle(1'b0, 0, 1'b1, 0);
        check("R4 refill vc0", cnt_of(0), DEPTH);
        cycle(1'b0, 0, 1'b1, 0);
        check("R6 no inc at full", cnt_of(0), DEPTH);
        check("R6 ovf pulse", int'(ovf_err), 1);
        cycle(1'b1, 0, 1'b1, 0);
        check("R5 paired at full", cnt_of(0), DEPTH);
        check("R5 no ovf when paired", int'(ovf_err), 0);
        cycle(1'b0, 0, 1'b1, 1);
        check("R4 refill vc1", cnt_of(1), DEPTH);
    endtask

    // Greedy sender on vc0, receiver returns each credit LAT cycles later.
    task automatic t_stream();
        bit dl [LAT];
        int sent = 0;
        int errs_seen = 0;
        for (int k = 0; k < LAT; k++) dl[k] = 1'b0;
        for (int i = 0; i < 40; i++) begin
            bit sv;
            sv = (i < 30) && may_send[0];
            send_valid = sv;
            send_vc    = '0;
            ret_valid  = dl[LAT-1];
            ret_vc     = '0;
            for (int k = LAT - 1; k > 0; k--) dl[k] = dl[k-1];
            dl[0] = sv;
            if (sv) sent++;
            @(posedge clk);
            @(negedge clk);
            if ((ovf_err | udf_err) != '0) errs_seen++;
        end
        send_valid = 1'b0;
        ret_valid  = 1'b0;
        check("R9 no errors in stream", errs_seen, 0);
        check("R9 refilled vc0", cnt_of(0), DEPTH);
        check("R9 traffic flowed", int'(sent >= 15), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_drain();
        t_underflow();
        t_paired();
        t_independent();
        t_overflow();
        t_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule